// File: doc/BRIEF.md
# Single-wire bus reset and presence responder

This block is the reset front end of a slave on a single-wire open-drain bus. It synchronizes the bus level and times every low pulse the master makes in whole microseconds. It decides whether a pulse is a bus reset, and it keeps track of whether the slave runs at standard speed or overdrive speed. After a valid reset, once the master releases the line, it waits a short delay and then pulls the line low for a fixed time. This pull is the presence answer. When the high window that follows has ended, it raises a one-cycle strobe so that the bit-level logic can start.

The length of the reset pulse sets the speed. A long reset always returns the slave to standard speed. In overdrive, a short reset keeps overdrive. An overdrive reset between the short and long limits still resets the slave and always selects standard speed. Entry into overdrive is ordered from outside by a one-cycle input. All timing comes from a microsecond tick that is divided down from the clock. The tick restarts at each measured falling edge and at each release that starts a response.

Top module: `owire_reset_responder`

## Requirements
- R1: Out of reset, `speed_od` is 0 (standard), `bus_pull_low` is 0 and `data_ready` is 0.
- R2: A cycle with `od_set` high switches `speed_od` to 1 in the next cycle, unless a reset is accepted in that same cycle.
- R3: At standard speed, a low pulse of at least STD_RST_US microseconds is a reset and leaves `speed_od` at 0. A shorter pulse produces no presence pull and no strobe, and it does not change the speed.
- R4: At overdrive, a low pulse of OD_RST_MIN_US up to and including OD_RST_MAX_US microseconds is a reset, and `speed_od` stays 1.
- R5: At overdrive, a low pulse longer than OD_RST_MAX_US microseconds is a reset and sets `speed_od` to 0. This covers both the middle range and pulses of STD_RST_US or more.
- R6: At overdrive, a low pulse shorter than OD_RST_MIN_US microseconds is ignored: there is no pull, no strobe and no change of speed.
- R7: Let the synchronized bus rise at cycle r after an accepted reset, and let P be CLKS_PER_US. `bus_pull_low` is then high exactly in cycles r+PDH·P+1 through r+(PDH+PDL)·P. PDH and PDL are the wait and pull lengths of the speed selected by that reset.
- R8: `data_ready` is high for exactly one cycle, at r+(PDH+PDL+REC)·P+1, where REC is the recovery length of that speed.
- R9: A low pulse whose falling edge arrives while a response is in progress is ignored. This includes the slave's own presence pull.
- R10: The bus input passes through two flops. A low pulse that is L cycles long at the synchronizer output measures floor((L-1)/P) microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Sampled bus level, 1 = released |
| od_set | input | 1 | One-cycle order to enter overdrive |
| bus_pull_low | output | 1 | Open-drain enable, 1 = pull the line low |
| speed_od | output | 1 | Current speed, 1 = overdrive |
| data_ready | output | 1 | One-cycle strobe at the end of the reset-high window |

## Verification
Every result is due at a fixed cycle. A change at `bus_in` reaches the synchronized level two edges later. A speed decision appears one cycle after the synchronized rise. The presence pull and the ready strobe follow the R7 and R8 formulas, counted from that rise. An `od_set` pulse shows on `speed_od` in the next cycle. The bench model replays the same two-flop delay and computes these cycle numbers from the parameter values alone. It then compares all three outputs at the falling clock edge of every cycle, so each result is sampled in the cycle it is due and in no other.

// File: rtl/owr_pkg.sv
package owr_pkg;

   typedef enum logic [1:0] {
      RSP_IDLE    = 2'd0,
      RSP_WAIT    = 2'd1,
      RSP_PULL    = 2'd2,
      RSP_RECOVER = 2'd3
   } rsp_state_e;

   typedef struct packed {
      logic hit;
      logic to_od;
   } rst_verdict_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/owr_sync.sv
module owr_sync #(
   parameter int STAGES     = 2,
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("owr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_LEVEL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/owr_us_tick.sv
module owr_us_tick #(
   parameter int CLKS_PER_US = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = $clog2(CLKS_PER_US);
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

   generate
      if (CLKS_PER_US < 2) begin : g_bad
         $error("owr_us_tick: CLKS_PER_US must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = !clr && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr || tick)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/owr_low_meter.sv
module owr_low_meter #(
   parameter int STD_RST_US = 480,
   localparam int LW = $clog2(STD_RST_US + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_s,
   input  logic          tick,
   input  logic          idle,
   output logic          fall_idle,
   output logic          rel_armed,
   output logic [LW-1:0] low_us
);
   localparam logic [LW-1:0] SAT = LW'(STD_RST_US);

   logic bus_d;
   logic armed;
   logic fall;
   logic rise;

   assign fall      = !bus_s && bus_d;
   assign rise      = bus_s && !bus_d;
   assign fall_idle = fall && idle;
   assign rel_armed = rise && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_d  <= 1'b1;
         armed  <= 1'b0;
         low_us <= '0;
      end else begin
         bus_d <= bus_s;
         if (fall)      armed <= idle;
         else if (rise) armed <= 1'b0;
         if (fall)
            low_us <= '0;
         else if (tick && !bus_s && (low_us != SAT))
            low_us <= low_us + 1'b1;
      end
   end

   // R9: an edge seen during a response never arms the classifier
   assert_busy_fall_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !idle) |=> !armed);
endmodule

// File: rtl/owr_responder.sv
module owr_responder
   import owr_pkg::*;
#(
   parameter int PDH_STD_US = 30,
   parameter int PDL_STD_US = 120,
   parameter int REC_STD_US = 5,
   parameter int PDH_OD_US  = 3,
   parameter int PDL_OD_US  = 12,
   parameter int REC_OD_US  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic use_od,
   input  logic tick,
   output logic busy,
   output logic pull,
   output logic ready
);
   localparam int MAXT = max_int(max_int(max_int(PDH_STD_US, PDL_STD_US), REC_STD_US),
                                 max_int(max_int(PDH_OD_US, PDL_OD_US), REC_OD_US));
   localparam int PW = $clog2(MAXT + 1);

   generate
      if (PDH_STD_US < 1 || PDL_STD_US < 1 || REC_STD_US < 1 ||
          PDH_OD_US < 1 || PDL_OD_US < 1 || REC_OD_US < 1) begin : g_bad
         $error("owr_responder: every phase length must be at least 1");
      end
   endgenerate

   rsp_state_e    state;
   logic [PW-1:0] phase;
   logic [PW-1:0] limit;
   logic          od_r;
   logic          ready_q;
   logic          last;

   always_comb begin
      unique case (state)
         RSP_WAIT:    limit = od_r ? PW'(PDH_OD_US) : PW'(PDH_STD_US);
         RSP_PULL:    limit = od_r ? PW'(PDL_OD_US) : PW'(PDL_STD_US);
         RSP_RECOVER: limit = od_r ? PW'(REC_OD_US) : PW'(REC_STD_US);
         default:     limit = PW'(1);
      endcase
   end

   assign last = tick && (phase == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RSP_IDLE;
         phase   <= '0;
         od_r    <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= (state == RSP_RECOVER) && last;
         if (start) begin
            state <= RSP_WAIT;
            phase <= '0;
            od_r  <= use_od;
         end else if (state != RSP_IDLE) begin
            if (last) begin
               phase <= '0;
               unique case (state)
                  RSP_WAIT:    state <= RSP_PULL;
                  RSP_PULL:    state <= RSP_RECOVER;
                  default:     state <= RSP_IDLE;
               endcase
            end else if (tick) begin
               phase <= phase + 1'b1;
            end
         end
      end
   end

   assign busy  = (state != RSP_IDLE);
   assign pull  = (state == RSP_PULL);
   assign ready = ready_q;

   // R9: a response is only ever launched from rest
   assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (state == RSP_IDLE));
   // R8: the strobe lasts one cycle
   assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
   // R8: the strobe arrives once the window has closed
   assert_ready_after_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!busy && !pull));
endmodule

// File: rtl/owire_reset_responder.sv
module owire_reset_responder
   import owr_pkg::*;
#(
   parameter int CLKS_PER_US   = 200,
   parameter int SYNC_STAGES   = 2,
   parameter int STD_RST_US    = 480,
   parameter int OD_RST_MIN_US = 48,
   parameter int OD_RST_MAX_US = 80,
   parameter int PDH_STD_US    = 30,
   parameter int PDL_STD_US    = 120,
   parameter int REC_STD_US    = 5,
   parameter int PDH_OD_US     = 3,
   parameter int PDL_OD_US     = 12,
   parameter int REC_OD_US     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_in,
   input  logic od_set,
   output logic bus_pull_low,
   output logic speed_od,
   output logic data_ready
);
   localparam int LW = $clog2(STD_RST_US + 1);
   localparam logic [LW-1:0] STD_MIN = LW'(STD_RST_US);
   localparam logic [LW-1:0] OD_MIN  = LW'(OD_RST_MIN_US);
   localparam logic [LW-1:0] OD_MAX  = LW'(OD_RST_MAX_US);

   generate
      if (OD_RST_MIN_US > OD_RST_MAX_US || OD_RST_MAX_US >= STD_RST_US) begin : g_bad
         $error("owire_reset_responder: reset limits must satisfy MIN <= MAX < STD");
      end
   endgenerate

   logic          bus_s;
   logic          tick;
   logic          tick_clr;
   logic          fall_idle;
   logic          rel_armed;
   logic [LW-1:0] low_us;
   logic          busy;
   logic          start;
   logic          speed_q;
   rst_verdict_t  verdict;

   owr_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
   );

   owr_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
   );

   owr_low_meter #(.STD_RST_US(STD_RST_US)) u_meter (
      .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .tick(tick), .idle(!busy),
      .fall_idle(fall_idle), .rel_armed(rel_armed), .low_us(low_us)
   );

   always_comb begin
      verdict = '0;
      if (low_us >= STD_MIN) begin
         verdict.hit   = 1'b1;
         verdict.to_od = 1'b0;
      end else if (speed_q && (low_us >= OD_MIN) && (low_us <= OD_MAX)) begin
         verdict.hit   = 1'b1;
         verdict.to_od = 1'b1;
      end else if (speed_q && (low_us > OD_MAX)) begin
         verdict.hit   = 1'b1;
         verdict.to_od = 1'b0;
      end
   end

   assign start    = rel_armed && verdict.hit;
   assign tick_clr = fall_idle || start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      speed_q <= 1'b0;
      else if (start)  speed_q <= verdict.to_od;
      else if (od_set) speed_q <= 1'b1;
   end

   owr_responder #(
      .PDH_STD_US(PDH_STD_US), .PDL_STD_US(PDL_STD_US), .REC_STD_US(REC_STD_US),
      .PDH_OD_US(PDH_OD_US),   .PDL_OD_US(PDL_OD_US),   .REC_OD_US(REC_OD_US)
   ) u_resp (
      .clk(clk), .rst_n(rst_n), .start(start), .use_od(verdict.to_od), .tick(tick),
      .busy(busy), .pull(bus_pull_low), .ready(data_ready)
   );

   assign speed_od = speed_q;

   // R3: a long low always ends at standard speed
   assert_long_low_std_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_armed && (low_us >= STD_MIN)) |=> (!speed_od && busy));
   // R2: the overdrive order lands one cycle later
   assert_od_set_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (od_set && !start) |=> speed_od);
   // R4: a short overdrive reset keeps overdrive
   assert_short_od_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_armed && speed_od && (low_us >= OD_MIN) && (low_us <= OD_MAX)) |=> (speed_od && busy));
   // R6: a glitch at overdrive launches nothing
   assert_od_glitch_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_armed && speed_od && (low_us < OD_MIN) && !od_set) |=> (speed_od && !busy));
endmodule

// File: tb/owire_reset_responder_bench.sv
module owire_reset_responder_bench;
   localparam int P      = 2;
   localparam int STD    = 480;
   localparam int OMIN   = 48;
   localparam int OMAX   = 80;
   localparam int PDH_S  = 30;
   localparam int PDL_S  = 120;
   localparam int REC_S  = 5;
   localparam int PDH_O  = 3;
   localparam int PDL_O  = 12;
   localparam int REC_O  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_low = 1'b0;
   logic od_set = 1'b0;
   logic bus_pull_low, speed_od, data_ready;
   logic bus_raw;

   always #2.5 clk = ~clk;

   assign bus_raw = !(m_low || bus_pull_low);

   owire_reset_responder #(
      .CLKS_PER_US(P), .STD_RST_US(STD), .OD_RST_MIN_US(OMIN), .OD_RST_MAX_US(OMAX),
      .PDH_STD_US(PDH_S), .PDL_STD_US(PDL_S), .REC_STD_US(REC_S),
      .PDH_OD_US(PDH_O), .PDL_OD_US(PDL_O), .REC_OD_US(REC_O)
   ) u_owire_reset_responder (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_raw), .od_set(od_set),
      .bus_pull_low(bus_pull_low), .speed_od(speed_od), .data_ready(data_ready)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int  cyc, f_cyc, rs, us;
   bit  s1, s2, sd, armed_m, spd_m, rsp_od, fall_m, rise_m, busy_m, hit_m, to_od_m;

   function automatic int pdh(input bit od); return od ? PDH_O : PDH_S; endfunction
   function automatic int pdl(input bit od); return od ? PDL_O : PDL_S; endfunction
   function automatic int rec(input bit od); return od ? REC_O : REC_S; endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc = 0; s1 = 1; s2 = 1; sd = 1; armed_m = 0; spd_m = 0;
         rs = -1000000; rsp_od = 0; f_cyc = 0;
      end else begin
         fall_m = !s2 && sd;
         rise_m = s2 && !sd;
         busy_m = (cyc >= rs + 1) && (cyc <= rs + (pdh(rsp_od) + pdl(rsp_od) + rec(rsp_od)) * P);
         hit_m = 0; to_od_m = 0;
         if (fall_m) begin
            armed_m = !busy_m;
            f_cyc = cyc;
         end else if (rise_m) begin
            if (armed_m) begin
               us = (cyc - f_cyc - 1) / P;
               if (us >= STD) hit_m = 1;
               else if (spd_m && us >= OMIN && us <= OMAX) begin hit_m = 1; to_od_m = 1; end
               else if (spd_m && us > OMAX) hit_m = 1;
               if (hit_m) begin spd_m = to_od_m; rs = cyc; rsp_od = to_od_m; end
            end
            armed_m = 0;
         end
         if (!hit_m && od_set) spd_m = 1;
         sd = s2; s2 = s1; s1 = bus_raw;
         cyc = cyc + 1;
      end
   end

   int pres_cnt = 0;
   int rdy_cnt = 0;
   bit pull_prev = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 R4 R5 speed", speed_od, spd_m);
         chk("R7 R10 pull", bus_pull_low,
             (cyc >= rs + pdh(rsp_od) * P + 1) && (cyc <= rs + (pdh(rsp_od) + pdl(rsp_od)) * P));
         chk("R8 ready", data_ready,
             cyc == rs + (pdh(rsp_od) + pdl(rsp_od) + rec(rsp_od)) * P + 1);
         if (bus_pull_low && !pull_prev) pres_cnt++;
         if (data_ready) rdy_cnt++;
      end
      pull_prev = bus_pull_low;
   end

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic low_us_pulse(input int n_us);
      @(negedge clk);
      m_low = 1'b1;
      repeat (n_us * P + 1) @(negedge clk);
      m_low = 1'b0;
   endtask

   task automatic settle(input bit od);
      idle_cycles(4 + (pdh(od) + pdl(od) + rec(od)) * P + 6);
   endtask

   task automatic pulse_od_set();
      @(negedge clk);
      od_set = 1'b1;
      @(negedge clk);
      od_set = 1'b0;
      idle_cycles(2);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         mismatched++;
         $display("FAIL R8 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int p0;
      idle_cycles(4);
      chk("R1 reset speed", speed_od, 0);
      chk("R1 reset pull", bus_pull_low, 0);
      chk("R1 reset ready", data_ready, 0);
      rst_n = 1'b1;
      idle_cycles(6);
      chk("R1 idle after reset", {bus_pull_low, speed_od, data_ready}, 0);

      // R3: standard speed, short pulses ignored
      low_us_pulse(100);
      settle(0);
      chk("R3 short ignored", pres_cnt, 0);
      low_us_pulse(STD - 1);
      settle(0);
      chk("R3 just below ignored", pres_cnt, 0);
      chk("R3 speed unchanged", speed_od, 0);
      // R3 R7 R8: minimum standard reset
      low_us_pulse(STD);
      settle(0);
      chk("R7 presence seen", pres_cnt, 1);
      chk("R8 strobe seen", rdy_cnt, 1);
      chk("R3 stays standard", speed_od, 0);

      // R2
      pulse_od_set();
      chk("R2 overdrive entered", speed_od, 1);

      // R6
      p0 = pres_cnt;
      low_us_pulse(OMIN - 1);
      settle(1);
      chk("R6 glitch no presence", pres_cnt, p0);
      chk("R6 glitch keeps speed", speed_od, 1);

      // R4
      low_us_pulse(60);
      settle(1);
      chk("R4 presence", pres_cnt, p0 + 1);
      chk("R4 keeps overdrive", speed_od, 1);
      low_us_pulse(OMAX);
      settle(1);
      chk("R4 upper bound keeps overdrive", speed_od, 1);
      chk("R4 upper bound presence", pres_cnt, p0 + 2);

      // R5
      low_us_pulse(OMAX + 1);
      settle(0);
      chk("R5 just above bound standard", speed_od, 0);
      pulse_od_set();
      low_us_pulse(200);
      settle(0);
      chk("R5 middle range standard", speed_od, 0);
      pulse_od_set();
      low_us_pulse(600);
      settle(0);
      chk("R5 long standard", speed_od, 0);
      chk("R5 presences", pres_cnt, p0 + 5);

      // R9: master low starting during the response is ignored
      p0 = pres_cnt;
      low_us_pulse(STD);
      idle_cycles(20);
      m_low = 1'b1;
      idle_cycles(1200);
      m_low = 1'b0;
      settle(0);
      chk("R9 busy low ignored", pres_cnt, p0 + 1);
      chk("R9 strobe once", rdy_cnt, 7);

      done = 1;
      summary();
      $finish;
   end
endmodule